// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a synchronous serial slave. An external host uses it to read and write a byte-addressed space of control registers and message memory inside the chip. The host holds an active-low select line low for the whole transaction. It clocks in an 8-bit start address first, then any number of data bytes. A direction pin sets whether the transaction writes or reads. All serial pins are brought into the system clock domain and their edges are detected there. The block turns completed bytes into single-cycle strobes on a simple internal memory port.

Successive bytes in one transaction go to successive addresses. The address counter steps only its low nibble and wraps it from 0xF back to 0x0, so the high nibble stays fixed for the whole transaction. On a read, the first location is fetched as soon as the address byte completes. A wait flag stays up until that fetched byte has been loaded into the output shifter. After that, each completed data byte starts the next fetch with no wait.

Top module: `ser_reg_slave`

## Requirements
- R1: While the chip select input is high, the block stays in its address phase. No write strobe is issued and any partial byte is discarded. The first byte after a new falling chip select is always taken as the address.
- R2: Serial input is sampled on rising serial clock edges, least significant bit first. The first 8 bits of a transaction form the start address.
- R3: In a write transaction (direction pin low when the address completes), each 8th data bit produces one single-cycle write strobe carrying the current address and the received byte. The address counter then advances.
- R4: In a read transaction (direction pin high), completion of the address byte issues a read strobe at that address. Each completed data byte issues another read strobe at the next address. A read of N data bytes therefore issues N+1 read strobes.
- R5: In a read, the serial output changes only on falling serial clock edges. It presents the fetched byte least significant bit first, and bit 0 is driven on the falling edge that precedes the first rising edge of the data byte.
- R6: During the data bytes of a read, the serial input is ignored and no write strobe is issued.
- R7: The address counter increments bits [3:0] modulo 16 and keeps bits [7:4] unchanged (0x3F is followed by 0x30, and 0xFF by 0xF0).
- R8: The wait output rises together with the address-phase read strobe and falls once the read data has been loaded. It is never raised in a write transaction or between data bytes.
- R9: After reset, the serial output, the wait output and both memory strobes are low.
- R10: The write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_din_i | input | 1 | Serial data from the host |
| ser_csn_i | input | 1 | Active-low transaction select |
| ser_rd_i | input | 1 | Direction: 1 read, 0 write |
| ser_dout_o | output | 1 | Serial read data to the host |
| wait_o | output | 1 | High while the first read fetch is pending |
| mem_addr_o | output | 8 | Memory access address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_re_o | output | 1 | Single-cycle read strobe |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |

## Verification
The assertions assume the memory returns read data one cycle after the read strobe. They also assume that every serial clock half-period lasts several system cycles, so that a fetch completes before the next falling edge and edges never arrive in back-to-back system cycles. The bench holds each serial clock half-period at 8 system cycles. It sets the direction pin and data line well before the edges that use them and opens each transaction with the serial clock idle high. It also toggles the serial input during read data bytes to show that this has no effect.

// File: rtl/ser_pkg.sv
package ser_pkg;
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } ser_phase_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int WIDTH   = 4,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/ser_addr_inc.sv
module ser_addr_inc #(
    parameter int ADDR_W = 8,
    parameter int WRAP_W = 4
) (
    input  logic [ADDR_W-1:0] cur_i,
    output logic [ADDR_W-1:0] next_o
);
    localparam int HOLD_W = ADDR_W - WRAP_W;

    logic [WRAP_W-1:0] low_next;
    assign low_next = cur_i[WRAP_W-1:0] + WRAP_W'(1);

    if (HOLD_W > 0) begin : g_hold
        assign next_o = {cur_i[ADDR_W-1:WRAP_W], low_next};
    end else begin : g_full
        assign next_o = low_next;
    end
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
    import ser_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int WRAP_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_din_i,
    input  logic              ser_csn_i,
    input  logic              ser_rd_i,
    output logic              ser_dout_o,
    output logic              wait_o,
    output logic [BYTE_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam int PIN_N = 4;

    typedef struct packed {
        ser_phase_e        phase;
        logic              rd;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] in_sh;
        logic [BYTE_W-1:0] out_sh;
        logic [BYTE_W-1:0] addr;
        logic              sclk_prev;
        logic              sdo;
        logic              wait_f;
        logic              we;
        logic              re;
        logic              cap;
        logic [BYTE_W-1:0] maddr;
        logic [BYTE_W-1:0] wdata;
    } eng_t;

    eng_t st_q, st_d;

    // Pin synchronisation: {dir, csn, sdi, sclk}; csn and sclk idle high
    logic [PIN_N-1:0] pins_s;
    ser_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0101)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_rd_i, ser_csn_i, ser_din_i, ser_clk_i}),
        .sync_o  (pins_s)
    );

    logic sclk_s, sdi_s, cs_act, dir_s;
    assign sclk_s = pins_s[0];
    assign sdi_s  = pins_s[1];
    assign cs_act = ~pins_s[2];
    assign dir_s  = pins_s[3];

    logic rise_w, fall_w;
    assign rise_w = sclk_s & ~st_q.sclk_prev;
    assign fall_w = ~sclk_s & st_q.sclk_prev;

    logic [BYTE_W-1:0] byte_w;
    assign byte_w = {sdi_s, st_q.in_sh[BYTE_W-1:1]};

    logic [BYTE_W-1:0] inc_new, inc_cur;
    ser_addr_inc #(.ADDR_W(BYTE_W), .WRAP_W(WRAP_W)) u_inc_new (
        .cur_i  (byte_w),
        .next_o (inc_new)
    );
    ser_addr_inc #(.ADDR_W(BYTE_W), .WRAP_W(WRAP_W)) u_inc_cur (
        .cur_i  (st_q.addr),
        .next_o (inc_cur)
    );

    always_comb begin
        st_d           = st_q;
        st_d.we        = 1'b0;
        st_d.re        = 1'b0;
        st_d.cap       = st_q.re;
        st_d.sclk_prev = sclk_s;
        if (!cs_act) begin
            st_d.phase   = PH_ADDR;
            st_d.rd      = 1'b0;
            st_d.bit_cnt = '0;
            st_d.in_sh   = '0;
            st_d.sdo     = 1'b0;
            st_d.wait_f  = 1'b0;
            st_d.cap     = 1'b0;
        end else begin
            if (fall_w && st_q.phase == PH_DATA && st_q.rd) begin
                st_d.sdo    = st_q.out_sh[0];
                st_d.out_sh = {1'b0, st_q.out_sh[BYTE_W-1:1]};
            end
            if (st_q.cap) begin
                st_d.out_sh = mem_rdata_i;
                st_d.wait_f = 1'b0;
            end
            if (rise_w) begin
                st_d.in_sh   = byte_w;
                st_d.bit_cnt = st_q.bit_cnt + CNT_W'(1);
                if (st_q.bit_cnt == LAST_BIT) begin
                    st_d.bit_cnt = '0;
                    if (st_q.phase == PH_ADDR) begin
                        st_d.phase = PH_DATA;
                        st_d.rd    = dir_s;
                        if (dir_s) begin
                            st_d.re     = 1'b1;
                            st_d.maddr  = byte_w;
                            st_d.addr   = inc_new;
                            st_d.wait_f = 1'b1;
                        end else begin
                            st_d.addr = byte_w;
                        end
                    end else if (st_q.rd) begin
                        st_d.re    = 1'b1;
                        st_d.maddr = st_q.addr;
                        st_d.addr  = inc_cur;
                    end else begin
                        st_d.we    = 1'b1;
                        st_d.maddr = st_q.addr;
                        st_d.wdata = byte_w;
                        st_d.addr  = inc_cur;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.phase     <= PH_ADDR;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_dout_o  = st_q.sdo;
    assign wait_o      = st_q.wait_f;
    assign mem_addr_o  = st_q.maddr;
    assign mem_wdata_o = st_q.wdata;
    assign mem_we_o    = st_q.we;
    assign mem_re_o    = st_q.re;

    // Assertion support: last access address within a transaction
    logic [BYTE_W-1:0] acc_prev_q;
    logic              acc_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_prev_q <= '0;
            acc_seen_q <= 1'b0;
        end else if (!cs_act) begin
            acc_seen_q <= 1'b0;
        end else if (mem_we_o || mem_re_o) begin
            acc_prev_q <= mem_addr_o;
            acc_seen_q <= 1'b1;
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!mem_we_o && !wait_o));

    // R8
    wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_o) |-> mem_re_o);

    // R8
    wait_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> !mem_we_o);

    // R8
    data_fetch_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && !$rose(wait_o)) |-> !wait_o);

    // R5
    sdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !fall_w) |=> $stable(ser_dout_o));

    // R7
    high_nibble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we_o || mem_re_o) && acc_seen_q && cs_act)
            |-> mem_addr_o[BYTE_W-1:WRAP_W] == acc_prev_q[BYTE_W-1:WRAP_W]);
endmodule

// File: tb/ser_reg_slave_tb.sv
module ser_reg_slave_tb_top;
    localparam int HALF = 8;
    localparam int NVEC = 8;
    // {rd, addr[7:0], len[3:0], seed[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 8'h10, 4'd3, 8'hA1},
        {1'b1, 8'h10, 4'd3, 8'h00},
        {1'b0, 8'h3E, 4'd4, 8'h17},
        {1'b1, 8'h3E, 4'd4, 8'h00},
        {1'b1, 8'h40, 4'd1, 8'h00},
        {1'b0, 8'hFF, 4'd2, 8'hC3},
        {1'b1, 8'hF0, 4'd1, 8'h00},
        {1'b1, 8'hFF, 4'd2, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sdi = 1'b0, csn = 1'b1, rd = 1'b0;
    logic sdo, wt, we, re;
    logic [7:0] maddr, wdata, rdata;

    always #2 clk = ~clk;

    ser_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_din_i(sdi), .ser_csn_i(csn), .ser_rd_i(rd),
        .ser_dout_o(sdo), .wait_o(wt),
        .mem_addr_o(maddr), .mem_wdata_o(wdata),
        .mem_we_o(we), .mem_re_o(re), .mem_rdata_i(rdata)
    );

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int we_cnt = 0, re_cnt = 0;
    logic [7:0] first_re_addr;
    logic first_re_seen = 1'b0;
    logic wait_seen = 1'b0;
    int checks = 0, failures = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        rdata = 8'h00;
    end

    always @(posedge clk) begin
        if (we) begin
            mem[maddr] <= wdata;
            we_cnt <= we_cnt + 1;
        end
        if (re) begin
            rdata <= mem[maddr];
            re_cnt <= re_cnt + 1;
            if (!first_re_seen) begin
                first_re_addr <= maddr;
                first_re_seen <= 1'b1;
            end
        end
        if (wt) wait_seen <= 1'b1;
    end

    function automatic logic [7:0] nxt(input logic [7:0] a);
        return {a[7:4], a[3:0] + 4'd1};
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic xbit(input logic b, output logic o);
        sclk = 1'b0;
        sdi = b;
        repeat (HALF) @(negedge clk);
        o = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        logic o;
        for (int k = 0; k < 8; k++) begin
            xbit(tx[k], o);
            rx[k] = o;
        end
    endtask

    task automatic open_txn(input logic dir, input logic [7:0] a);
        logic [7:0] dummy;
        rd = dir;
        repeat (4) @(negedge clk);
        csn = 1'b0;
        repeat (4) @(negedge clk);
        wait_seen = 1'b0;
        first_re_seen = 1'b0;
        xbyte(a, dummy);
    endtask

    task automatic close_txn();
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic run_txn(input logic dir, input logic [7:0] a, input int n, input logic [7:0] seed);
        logic [7:0] rx, cur, tx;
        int we0, re0;
        we0 = we_cnt;
        re0 = re_cnt;
        open_txn(dir, a);
        check(wait_seen == dir, "R8 wait in address gap", int'(wait_seen), int'(dir));
        wait_seen = 1'b0;
        cur = a;
        for (int i = 0; i < n; i++) begin
            if (dir) begin
                tx = (i % 2 == 0) ? 8'hFF : 8'h55;
                xbyte(tx, rx);
                check(rx == exp_mem[cur], "R5 read data", int'(rx), int'(exp_mem[cur]));
            end else begin
                tx = seed + 8'(i * 37);
                xbyte(tx, rx);
                exp_mem[cur] = tx;
            end
            cur = nxt(cur);
        end
        check(wait_seen == 1'b0, "R8 no wait between data bytes", int'(wait_seen), 0);
        close_txn();
        if (dir) begin
            check(we_cnt == we0, "R6 no write during read", we_cnt - we0, 0);
            check(re_cnt - re0 == n + 1, "R4 fetch count", re_cnt - re0, n + 1);
            check(first_re_addr == a, "R4 first fetch address", int'(first_re_addr), int'(a));
        end else begin
            check(we_cnt - we0 == n, "R3 write count", we_cnt - we0, n);
            check(re_cnt == re0, "R3 no fetch in write", re_cnt - re0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic o;
        int we0;
        repeat (5) @(negedge clk);
        // R9 reset state
        check(sdo == 1'b0 && wt == 1'b0, "R9 outputs at reset", {sdo, wt}, 0);
        check(we == 1'b0 && re == 1'b0, "R9 strobes at reset", {we, re}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(we == 1'b0 && re == 1'b0 && wt == 1'b0, "R9 idle after reset", {we, re, wt}, 0);

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            run_txn(VEC[v][20], VEC[v][19:12], int'(VEC[v][11:8]), VEC[v][7:0]);
        end
        // R7 wrap targets explicitly
        check(mem[8'h30] == exp_mem[8'h30], "R7 wrap 3F->30", int'(mem[8'h30]), int'(exp_mem[8'h30]));
        check(mem[8'h40] == (8'h40 ^ 8'h5A), "R7 upper nibble held", int'(mem[8'h40]), int'(8'h40 ^ 8'h5A));
        check(mem[8'hF0] == exp_mem[8'hF0], "R7 wrap FF->F0", int'(mem[8'hF0]), int'(exp_mem[8'hF0]));

        // R1 partial data byte discarded by chip select high
        we0 = we_cnt;
        open_txn(1'b0, 8'h20);
        for (int k = 0; k < 5; k++) xbit(1'b1, o);
        close_txn();
        check(we_cnt == we0, "R1 partial byte not written", we_cnt - we0, 0);
        // R1 next transaction takes first byte as address
        open_txn(1'b1, 8'h20);
        xbyte(8'h00, rx);
        close_txn();
        check(rx == exp_mem[8'h20], "R1 new address after reselect", int'(rx), int'(exp_mem[8'h20]));

        // R2 single-byte write with asymmetric pattern, then readback
        run_txn(1'b0, 8'h81, 1, 8'h2C);
        open_txn(1'b1, 8'h81);
        xbyte(8'h00, rx);
        close_txn();
        check(rx == 8'h2C, "R2 LSB-first round trip", int'(rx), 8'h2C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule